// File: doc/BRIEF.md
# Synthesizer Lock Flag Detector

This block decides whether a frequency synthesizer loop is in lock by timing the pulses that the phase comparator sends to the charge pump. It runs on the crystal clock. The up and down pump requests arrive from the analog comparator without any timing relation to that clock, so they pass through a synchronizer first. Their combined activity is then timed in whole crystal cycles. A strobe from the reference divider marks the end of each reference period.

Any pump pulse that lasts longer than the allowed number of crystal cycles (one by default) drops the lock flag at once. This gives an unlock response within one reference period. Raising the flag again is deliberately slow. The detector needs a run of consecutive reference periods in which every pulse stayed narrow, eight by default. A single wide pulse anywhere in that run restarts the count. At a 62.5 kHz reference, the flag therefore rises 128 to 144 µs after the loop settles. A flag value of 1 means the loop is locked.

Top module: `lock_flag_detector`

## Requirements
- R1: After reset the lock flag is 0 and the count of clean periods is zero.
- R2: Each pump request passes through a two-stage synchronizer. A level applied at clock edge k is first seen by the timing logic in the cycle that follows edge k+1.
- R3: When synchronized pump activity lasts longer than MAX_CLEAN_CYC cycles, the flag goes to 0 at the clock edge that ends the first over-long cycle. For a wide request first sampled at edge k, this is edge k+3 with the default values.
- R4: Activity that lasts MAX_CLEAN_CYC cycles or fewer has no effect on the flag or on the clean-period count.
- R5: The flag becomes 1 at the strobe edge that completes the LOCK_RUN-th consecutive clean period. It does not rise at any earlier strobe.
- R6: A wide pulse inside a period restarts the clean-period count from zero. The period that holds the wide pulse does not count as clean.
- R7: Up and down activity are ORed before timing. Two single-cycle requests in back-to-back cycles, one on up and one on down, form one pulse two cycles wide.
- R8: Once the flag is 1, further clean periods keep it at 1.
- R9: A wide cycle that falls in the same cycle as the strobe makes the period that is closing unclean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal clock; all state is timed by this clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pump_up_i | input | 1 | Up pump request (asynchronous) |
| pump_dn_i | input | 1 | Down pump request (asynchronous) |
| ref_stb_i | input | 1 | One-cycle strobe in the last cycle of each reference period |
| lock_o | output | 1 | Lock flag, 1 = locked |

## Verification
A request applied at edge k reaches the timing logic after edge k+1, because of the two synchronizer stages. A wide pulse therefore clears the flag no earlier than edge k+3. A rise of the flag appears right after the strobe edge that closes the qualifying period. The bench keeps a behavioural model that delays the stimulus history by the same two edges and updates at each rising edge. The flag is compared with this model at every falling edge, which is half a cycle after any change the design can make. Named checks after specific periods confirm R5, R6, R8 and R9 at the exact period boundary.

// File: rtl/lfd_pkg.sv
package lfd_pkg;
  // Saturating increment for an unsigned counter with an upper bound.
  function automatic int unsigned sat_inc(input int unsigned cnt, input int unsigned top);
    return (cnt >= top) ? top : cnt + 1;
  endfunction

  // Activity is wide once it has already been present for max_clean cycles.
  function automatic logic is_wide(input logic act, input int unsigned prior, input int unsigned max_clean);
    return act && (prior >= max_clean);
  endfunction
endpackage

// File: rtl/lfd_sync.sv
module lfd_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/lfd_width_meter.sv
module lfd_width_meter
  import lfd_pkg::*;
#(
  parameter int unsigned MAX_CLEAN_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  output logic wide_o
);
  localparam int unsigned CNT_W = (MAX_CLEAN_CYC < 2) ? 1 : $clog2(MAX_CLEAN_CYC + 1);

  logic [CNT_W-1:0] prior_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prior_q <= '0;
    else if (act_i) prior_q <= CNT_W'(sat_inc(int'(prior_q), MAX_CLEAN_CYC));
    else            prior_q <= '0;
  end

  assign wide_o = is_wide(act_i, int'(prior_q), MAX_CLEAN_CYC);

  // R4: a gap in activity restarts the width measurement
  p_gap_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> !wide_o);
endmodule

// File: rtl/lfd_lock_qual.sv
module lfd_lock_qual
  import lfd_pkg::*;
#(
  parameter int unsigned LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wide_i,
  input  logic stb_i,
  output logic lock_o
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);

  logic [RUN_W-1:0] run_q;
  logic             dirty_q;
  logic             lock_q;
  logic             period_clean;
  logic [RUN_W-1:0] run_next;

  assign period_clean = stb_i && !dirty_q && !wide_i;
  assign run_next     = RUN_W'(sat_inc(int'(run_q), LOCK_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      dirty_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      dirty_q <= stb_i ? 1'b0 : (dirty_q | wide_i);
      if (wide_i) begin
        run_q  <= '0;
        lock_q <= 1'b0;
      end else if (period_clean) begin
        run_q <= run_next;
        if (run_next == RUN_W'(LOCK_RUN)) lock_q <= 1'b1;
      end
    end
  end

  assign lock_o = lock_q;

  p_wide_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wide_i |=> !lock_o);
  p_wide_restarts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wide_i |=> (run_q == '0));
  p_rise_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(stb_i));
  p_rise_after_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> ($past(run_q) == RUN_W'(LOCK_RUN - 1)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !wide_i) |=> lock_o);
endmodule

// File: rtl/lock_flag_detector.sv
module lock_flag_detector #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned MAX_CLEAN_CYC = 1,
  parameter int unsigned LOCK_RUN      = 8
) (
  input  logic clk_xtal,
  input  logic rst_n,
  input  logic pump_up_i,
  input  logic pump_dn_i,
  input  logic ref_stb_i,
  output logic lock_o
);
  logic [1:0] pump_s;
  logic       pump_act;
  logic       wide_evt;

  lfd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_xtal), .rst_n(rst_n),
    .d_i({pump_dn_i, pump_up_i}), .q_o(pump_s)
  );

  assign pump_act = |pump_s; // R7: either direction counts

  lfd_width_meter #(.MAX_CLEAN_CYC(MAX_CLEAN_CYC)) u_meter (
    .clk(clk_xtal), .rst_n(rst_n), .act_i(pump_act), .wide_o(wide_evt)
  );

  lfd_lock_qual #(.LOCK_RUN(LOCK_RUN)) u_qual (
    .clk(clk_xtal), .rst_n(rst_n), .wide_i(wide_evt),
    .stb_i(ref_stb_i), .lock_o(lock_o)
  );

  p_reset_low_r1: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    !$past(rst_n) |-> !lock_o);
  p_wide_needs_activity_r2: assert property (@(posedge clk_xtal) disable iff (!rst_n)
    wide_evt |-> pump_act);
endmodule

// File: tb/sim_lock_flag_detector.sv
`timescale 1ns/1ps
module sim_lock_flag_detector;
  localparam int REF = 16;
  localparam int MAXC = 1;
  localparam int RUN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up = 1'b0, dn = 1'b0, stb = 1'b0;
  logic lock;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2 clk = ~clk;

  lock_flag_detector u0 (
    .clk_xtal(clk), .rst_n(rst_n), .pump_up_i(up), .pump_dn_i(dn),
    .ref_stb_i(stb), .lock_o(lock)
  );

  // behavioural reference model
  bit hist[$];
  int m_len = 0, m_run = 0;
  bit m_lock = 0, m_bad = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {1'b0, 1'b0};
      m_len = 0; m_run = 0; m_lock = 0; m_bad = 0;
    end else begin
      bit act, wide;
      hist.push_back(up | dn);
      act = hist.pop_front();
      m_len = act ? m_len + 1 : 0;
      wide = act && (m_len > MAXC);
      if (wide) begin m_lock = 0; m_run = 0; m_bad = 1; end
      if (stb) begin
        if (!m_bad) begin
          if (m_run < RUN) m_run++;
          if (m_run == RUN) m_lock = 1;
        end
        m_bad = 0;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    tests++;
    if (lock !== m_lock) begin
      fails++;
      $display("FAIL %s per-cycle: lock actual=%b expected=%b at %0t", cur_req, lock, m_lock, $time);
    end
  end

  task automatic check(input string req, input bit exp);
    tests++;
    if (lock !== exp) begin
      fails++;
      $display("FAIL %s: lock actual=%b expected=%b", req, lock, exp);
    end
  endtask

  // one reference period; pulses given by start cycle and length (0 = none)
  task automatic period(input int ua, input int ul, input int da, input int dl);
    for (int c = 0; c < REF; c++) begin
      @(negedge clk);
      up  = (c >= ua) && (c < ua + ul);
      dn  = (c >= da) && (c < da + dl);
      stb = (c == REF - 1);
    end
    @(negedge clk);
    up = 0; dn = 0; stb = 0;
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) period(3, 1, 8, 1);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1"; check("R1", 0);

    cur_req = "R5"; clean(RUN - 1);
    repeat (3) @(negedge clk);
    check("R5", 0);
    clean(1);
    check("R5", 1);

    cur_req = "R8"; clean(3);
    check("R8", 1);

    cur_req = "R4"; period(2, 1, 6, 1);
    check("R4", 1);

    cur_req = "R3"; period(4, 2, 0, 0);
    check("R3", 0);

    cur_req = "R6"; clean(5); period(0, 0, 5, 3); clean(RUN - 1);
    check("R6", 0);
    clean(1);
    check("R6", 1);

    cur_req = "R7"; period(4, 1, 5, 1);
    check("R7", 0);
    clean(RUN);
    check("R7", 1);

    cur_req = "R9"; clean(2); period(12, 2, 0, 0);
    check("R9", 0);
    clean(RUN - 1);
    check("R9", 0);
    clean(1);
    check("R9", 1);

    cur_req = "R2"; period(0, 0, 1, 4);
    check("R2", 0);

    cur_req = "R1"; rst_n = 1'b0;
    @(negedge clk);
    check("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule